// File: doc/BRIEF.md
# Ordered Inbound Queue With Commit Bypass

This block sits at a node's entry point for the globally ordered message channel coming from home nodes. It buffers forwards, invalidations, replies and commit events in arrival order and hands them to the cache one at a time. It does not dequeue strictly first-in-first-out. A reply may leave ahead of older forwards and invalidations. A commit event never leaves ahead of anything older, so no older invalidation or forward is ever overtaken by a commit.

The block also supports memory barriers. Each store the node issues raises an outstanding-commit count. Each commit event handed to the cache lowers it. A barrier request completes once every store issued up to that request has seen its commit dequeued. Invalidations and forwards are acknowledged on the cycle they are accepted, before the cache handles them. That early acknowledgement is what makes commit-based barrier completion safe.

Top module: `ord_inq`

## Requirements
- R1: After reset, `in_ready_o` is 1 and `out_valid_o`, `barrier_done_o` and `overflow_o` are 0.
- R2: Message kind codes on `in_kind_i`/`out_kind_o` are: 0 read forward, 1 read-exclusive forward, 2 exclusive forward, 3 invalidation, 4 reply, 5 commit. Forwards and invalidations leave in arrival order among themselves.
- R3: A reply with no older reply or commit still queued is dequeued before any older forward or invalidation. Replies leave in arrival order among themselves.
- R4: A commit leaves only when it is the oldest entry. It never leaves before an older forward, invalidation or reply, and no younger entry leaves before it except a reply that is older than the commit.
- R5: With 8 entries held (DEPTH), `in_ready_o` is 0 and an offered message is not stored.
- R6: `ack_o` is 1 in exactly the cycle in which a forward or invalidation (kinds 0 to 3) is accepted. It is 0 for replies, commits and refused offers.
- R7: After a barrier request with N stores outstanding, `barrier_done_o` pulses for one cycle, in the cycle after the Nth commit is dequeued. Stores issued after the request do not delay it.
- R8: A barrier request with no stores outstanding gives a `barrier_done_o` pulse in the next cycle.
- R9: The outstanding-commit count saturates at 2^CNT_W-1. A store issued at saturation sets `overflow_o`, which stays 1 until reset.
- R10: `out_valid_o` is 1 exactly when at least one entry is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Incoming message valid |
| in_kind_i | input | 3 | Incoming message kind code |
| in_pay_i | input | PAY_W | Incoming message payload (address tag / id) |
| in_ready_o | output | 1 | Queue can accept a message |
| ack_o | output | 1 | Early acknowledgement of an accepted forward/invalidation |
| out_valid_o | output | 1 | An entry is offered to the cache |
| out_kind_o | output | 3 | Kind of the offered entry |
| out_pay_o | output | PAY_W | Payload of the offered entry |
| out_ready_i | input | 1 | Cache takes the offered entry |
| store_issue_i | input | 1 | Node issued a store this cycle |
| barrier_req_i | input | 1 | Memory barrier request strobe |
| barrier_done_o | output | 1 | One-cycle barrier completion pulse |
| overflow_o | output | 1 | Sticky outstanding-commit saturation flag |

## Verification
The assertions take for granted that `in_kind_i` carries only codes 0 to 5 while `in_valid_i` is high. They also assume a new barrier request is raised only after the previous one has completed, because a request made while one is pending is ignored. The directed stimulus offers only legal kinds and waits for each `barrier_done_o` pulse before making the next request. Commits are delivered only for stores the bench has issued, apart from the ordering scenarios, which run while no barrier is pending. Stimulus is applied on the falling edge, so every input is stable across the capturing edge.

// File: rtl/ord_inq_pkg.sv
package ord_inq_pkg;

  typedef enum logic [2:0] {
    MSG_FWD_RD  = 3'd0,
    MSG_FWD_RDX = 3'd1,
    MSG_FWD_EX  = 3'd2,
    MSG_INVAL   = 3'd3,
    MSG_REPLY   = 3'd4,
    MSG_COMMIT  = 3'd5
  } msg_kind_e;

  // kinds acknowledged at enqueue and never overtaken by a commit
  function automatic logic is_ordered_kind(msg_kind_e k);
    return (k == MSG_FWD_RD) || (k == MSG_FWD_RDX) ||
           (k == MSG_FWD_EX) || (k == MSG_INVAL);
  endfunction

endpackage

// File: rtl/ord_inq_store.sv
// Age-ordered entry store; slot 0 is oldest, removal compacts younger slots down.
module ord_inq_store
  import ord_inq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int PAY_W  = 8,
  parameter int IDX_W  = $clog2(DEPTH),
  parameter int FILL_W = $clog2(DEPTH + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               push_i,
  input  msg_kind_e          push_kind_i,
  input  logic [PAY_W-1:0]   push_pay_i,
  input  logic               pop_i,
  input  logic [IDX_W-1:0]   pop_idx_i,
  output msg_kind_e          kind_o [DEPTH],
  output logic [PAY_W-1:0]   pay_o  [DEPTH],
  output logic [FILL_W-1:0]  fill_o
);

  msg_kind_e          kind_q [DEPTH];
  logic [PAY_W-1:0]   pay_q  [DEPTH];
  msg_kind_e          kind_d [DEPTH];
  logic [PAY_W-1:0]   pay_d  [DEPTH];
  logic [FILL_W-1:0]  fill_q;
  logic [FILL_W-1:0]  fill_after_pop;

  assign fill_after_pop = fill_q - FILL_W'(pop_i);

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      kind_d[i] = kind_q[i];
      pay_d[i]  = pay_q[i];
    end
    if (pop_i) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        if (i >= int'(pop_idx_i)) begin
          kind_d[i] = kind_q[i+1];
          pay_d[i]  = pay_q[i+1];
        end
      end
    end
    if (push_i) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (fill_after_pop == FILL_W'(i)) begin
          kind_d[i] = push_kind_i;
          pay_d[i]  = push_pay_i;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        kind_q[i] <= MSG_FWD_RD;
        pay_q[i]  <= '0;
      end
    end else begin
      fill_q <= fill_after_pop + FILL_W'(push_i);
      for (int i = 0; i < DEPTH; i++) begin
        kind_q[i] <= kind_d[i];
        pay_q[i]  <= pay_d[i];
      end
    end
  end

  assign kind_o = kind_q;
  assign pay_o  = pay_q;
  assign fill_o = fill_q;

endmodule

// File: rtl/ord_inq_pick.sv
// Dequeue selection: oldest reply not behind another reply or a commit, else head.
module ord_inq_pick
  import ord_inq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int IDX_W  = $clog2(DEPTH),
  parameter int FILL_W = $clog2(DEPTH + 1)
) (
  input  msg_kind_e          kind_i [DEPTH],
  input  logic [FILL_W-1:0]  fill_i,
  output logic               valid_o,
  output logic [IDX_W-1:0]   idx_o
);

  logic [DEPTH-1:0] live;
  logic [DEPTH-1:0] cand;
  logic [DEPTH:0]   barrier_seen;

  assign barrier_seen[0] = 1'b0;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    assign live[i] = FILL_W'(i) < fill_i;
    assign cand[i] = live[i] && (kind_i[i] == MSG_REPLY) && !barrier_seen[i];
    assign barrier_seen[i+1] = barrier_seen[i] |
        (live[i] && ((kind_i[i] == MSG_REPLY) || (kind_i[i] == MSG_COMMIT)));
  end

  always_comb begin
    idx_o = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (cand[i]) idx_o = IDX_W'(i);
    end
  end

  assign valid_o = fill_i != '0;

endmodule

// File: rtl/ord_inq_commit_trk.sv
// Outstanding-commit counter and barrier completion.
module ord_inq_commit_trk #(
  parameter int CNT_W = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic store_i,
  input  logic commit_pop_i,
  input  logic bar_req_i,
  output logic done_o,
  output logic ovf_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] outst_q, outst_d;
  logic             ovf_q, ovf_set;
  logic             pend_q;
  logic [CNT_W-1:0] wait_q;
  logic             done_q;

  always_comb begin
    outst_d = outst_q;
    ovf_set = 1'b0;
    unique case ({store_i, commit_pop_i})
      2'b10: begin
        if (outst_q == CNT_MAX) ovf_set = 1'b1;
        else                    outst_d = outst_q + 1'b1;
      end
      2'b01: if (outst_q != '0) outst_d = outst_q - 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      outst_q <= '0;
      ovf_q   <= 1'b0;
      pend_q  <= 1'b0;
      wait_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      outst_q <= outst_d;
      ovf_q   <= ovf_q | ovf_set;
      done_q  <= 1'b0;
      if (!pend_q && bar_req_i) begin
        // same-cycle store counts before the barrier, same-cycle commit is consumed
        if (outst_d == '0) begin
          done_q <= 1'b1;
        end else begin
          pend_q <= 1'b1;
          wait_q <= outst_d;
        end
      end else if (pend_q && commit_pop_i) begin
        wait_q <= wait_q - 1'b1;
        if (wait_q == CNT_W'(1)) begin
          pend_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign ovf_o  = ovf_q;

endmodule

// File: rtl/ord_inq.sv
module ord_inq
  import ord_inq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int PAY_W = 8,
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic [2:0]       in_kind_i,
  input  logic [PAY_W-1:0] in_pay_i,
  output logic             in_ready_o,
  output logic             ack_o,
  output logic             out_valid_o,
  output logic [2:0]       out_kind_o,
  output logic [PAY_W-1:0] out_pay_o,
  input  logic             out_ready_i,
  input  logic             store_issue_i,
  input  logic             barrier_req_i,
  output logic             barrier_done_o,
  output logic             overflow_o
);

  localparam int IDX_W  = $clog2(DEPTH);
  localparam int FILL_W = $clog2(DEPTH + 1);

  msg_kind_e          slot_kind [DEPTH];
  logic [PAY_W-1:0]   slot_pay  [DEPTH];
  logic [FILL_W-1:0]  fill;
  logic [IDX_W-1:0]   sel_idx;
  logic               sel_valid;
  msg_kind_e          in_kind;
  msg_kind_e          sel_kind;
  logic               push, pop, commit_pop;

  assign in_kind    = msg_kind_e'(in_kind_i);
  assign in_ready_o = fill != FILL_W'(DEPTH);
  assign push       = in_valid_i && in_ready_o;
  assign ack_o      = push && is_ordered_kind(in_kind);

  assign sel_kind    = slot_kind[sel_idx];
  assign out_valid_o = sel_valid;
  assign out_kind_o  = sel_kind;
  assign out_pay_o   = slot_pay[sel_idx];
  assign pop         = sel_valid && out_ready_i;
  assign commit_pop  = pop && (sel_kind == MSG_COMMIT);

  ord_inq_store #(.DEPTH(DEPTH), .PAY_W(PAY_W)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push),
    .push_kind_i (in_kind),
    .push_pay_i  (in_pay_i),
    .pop_i       (pop),
    .pop_idx_i   (sel_idx),
    .kind_o      (slot_kind),
    .pay_o       (slot_pay),
    .fill_o      (fill)
  );

  ord_inq_pick #(.DEPTH(DEPTH)) u_pick (
    .kind_i  (slot_kind),
    .fill_i  (fill),
    .valid_o (sel_valid),
    .idx_o   (sel_idx)
  );

  ord_inq_commit_trk #(.CNT_W(CNT_W)) u_trk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .store_i      (store_issue_i),
    .commit_pop_i (commit_pop),
    .bar_req_i    (barrier_req_i),
    .done_o       (barrier_done_o),
    .ovf_o        (overflow_o)
  );

endmodule

// File: rtl/ord_inq_chk.sv
module ord_inq_chk #(
  parameter int DEPTH = 8,
  parameter int PAY_W = 8,
  parameter int CNT_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_valid_i,
  input logic [2:0]       in_kind_i,
  input logic [PAY_W-1:0] in_pay_i,
  input logic             in_ready_o,
  input logic             ack_o,
  input logic             out_valid_o,
  input logic [2:0]       out_kind_o,
  input logic [PAY_W-1:0] out_pay_o,
  input logic             out_ready_i,
  input logic             store_issue_i,
  input logic             barrier_req_i,
  input logic             barrier_done_o,
  input logic             overflow_o
);

  localparam int FILL_W = $clog2(DEPTH + 1);

  logic [FILL_W-1:0] occ_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) occ_q <= '0;
    else occ_q <= occ_q + FILL_W'(in_valid_i && in_ready_o)
                        - FILL_W'(out_valid_o && out_ready_i);
  end

  AST_READY_TRACKS_OCC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o == (occ_q != FILL_W'(DEPTH))); // R5
  AST_VALID_TRACKS_OCC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o == (occ_q != '0)); // R10
  AST_ACK_ON_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> (in_valid_i && in_ready_o)); // R6
  AST_ACK_KIND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> (in_kind_i < 3'd4)); // R6
  AST_DONE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    barrier_done_o |-> ($past(barrier_req_i) ||
                        $past(out_valid_o && out_ready_i && out_kind_o == 3'd5))); // R7
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o); // R9

endmodule

bind ord_inq ord_inq_chk #(.DEPTH(DEPTH), .PAY_W(PAY_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/ord_inq_tb.sv
module ord_inq_tb;
  import ord_inq_pkg::*;

  localparam int PAY_W = 8;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             in_valid = 1'b0;
  logic [2:0]       in_kind = '0;
  logic [PAY_W-1:0] in_pay = '0;
  logic             in_ready, ack;
  logic             out_valid;
  logic [2:0]       out_kind;
  logic [PAY_W-1:0] out_pay;
  logic             out_ready = 1'b0;
  logic             store_issue = 1'b0;
  logic             barrier_req = 1'b0;
  logic             barrier_done, overflow;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  ord_inq #(.DEPTH(8), .PAY_W(PAY_W), .CNT_W(4)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .in_valid_i(in_valid), .in_kind_i(in_kind), .in_pay_i(in_pay),
    .in_ready_o(in_ready), .ack_o(ack),
    .out_valid_o(out_valid), .out_kind_o(out_kind), .out_pay_o(out_pay),
    .out_ready_i(out_ready),
    .store_issue_i(store_issue), .barrier_req_i(barrier_req),
    .barrier_done_o(barrier_done), .overflow_o(overflow)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic enq(input msg_kind_e k, input int pay, output logic got_ack);
    @(negedge clk);
    in_valid = 1'b1; in_kind = k; in_pay = PAY_W'(pay);
    #2 got_ack = ack;
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic enq_ack(input string req, input msg_kind_e k, input int pay);
    logic a;
    enq(k, pay, a);
    chk(req, int'(a), (k < MSG_REPLY) ? 1 : 0);
  endtask

  task automatic deq(input string req, input msg_kind_e k, input int pay);
    @(negedge clk);
    #2;
    chk(req, int'(out_valid), 1);
    chk(req, int'(out_kind), int'(k));
    chk(req, int'(out_pay), pay);
    out_ready = 1'b1;
    @(posedge clk);
    #1 out_ready = 1'b0;
  endtask

  task automatic store_pulse();
    @(negedge clk); store_issue = 1'b1;
    @(posedge clk); #1 store_issue = 1'b0;
  endtask

  task automatic bar_pulse();
    @(negedge clk); barrier_req = 1'b1;
    @(posedge clk); #1 barrier_req = 1'b0;
  endtask

  task automatic sample_done(input string req, input int exp);
    @(negedge clk); #2;
    chk(req, int'(barrier_done), exp);
  endtask

  task automatic t_reset();
    #2;
    chk("R1 ready", int'(in_ready), 1);
    chk("R1 valid", int'(out_valid), 0);
    chk("R1 done", int'(barrier_done), 0);
    chk("R1 ovf", int'(overflow), 0);
  endtask

  task automatic t_fifo();
    enq_ack("R6 fwd_rd", MSG_FWD_RD, 1);
    enq_ack("R6 inval", MSG_INVAL, 2);
    enq_ack("R6 fwd_ex", MSG_FWD_EX, 3);
    deq("R2 order0", MSG_FWD_RD, 1);
    deq("R2 order1", MSG_INVAL, 2);
    deq("R2 order2", MSG_FWD_EX, 3);
    @(negedge clk); #2 chk("R10 empty", int'(out_valid), 0);
  endtask

  task automatic t_bypass();
    enq_ack("R6 inval", MSG_INVAL, 10);
    enq_ack("R6 fwd_rd", MSG_FWD_RD, 11);
    enq_ack("R6 reply", MSG_REPLY, 12);
    enq_ack("R6 reply", MSG_REPLY, 13);
    deq("R3 first reply", MSG_REPLY, 12);
    deq("R3 second reply", MSG_REPLY, 13);
    deq("R3 inval after", MSG_INVAL, 10);
    deq("R3 fwd after", MSG_FWD_RD, 11);
  endtask

  task automatic t_commit();
    enq_ack("R6 inval", MSG_INVAL, 20);
    enq_ack("R6 commit", MSG_COMMIT, 21);
    enq_ack("R6 reply", MSG_REPLY, 22);
    enq_ack("R6 fwd_rdx", MSG_FWD_RDX, 23);
    enq_ack("R6 commit", MSG_COMMIT, 24);
    enq_ack("R6 fwd_ex", MSG_FWD_EX, 25);
    deq("R4 inval before commit", MSG_INVAL, 20);
    deq("R4 commit", MSG_COMMIT, 21);
    deq("R4 reply held by commit", MSG_REPLY, 22);
    deq("R4 fwd_rdx before commit", MSG_FWD_RDX, 23);
    deq("R4 commit", MSG_COMMIT, 24);
    deq("R4 fwd_ex", MSG_FWD_EX, 25);
    enq_ack("R6 inval", MSG_INVAL, 30);
    enq_ack("R6 reply", MSG_REPLY, 31);
    enq_ack("R6 commit", MSG_COMMIT, 32);
    deq("R3 reply passes inval", MSG_REPLY, 31);
    deq("R4 inval before commit", MSG_INVAL, 30);
    deq("R4 commit last", MSG_COMMIT, 32);
  endtask

  task automatic t_full();
    logic a;
    for (int i = 0; i < 8; i++) enq_ack("R6 fill", MSG_INVAL, 40 + i);
    @(negedge clk); #2 chk("R5 not ready", int'(in_ready), 0);
    enq(MSG_FWD_RD, 99, a);
    chk("R6 refused no ack", int'(a), 0);
    for (int i = 0; i < 8; i++) deq("R5 drain", MSG_INVAL, 40 + i);
    @(negedge clk); #2;
    chk("R5 dropped", int'(out_valid), 0);
    chk("R5 ready again", int'(in_ready), 1);
  endtask

  task automatic t_barrier_zero();
    bar_pulse();
    sample_done("R8 done", 1);
    sample_done("R8 pulse ends", 0);
  endtask

  task automatic t_barrier_wait();
    logic a;
    store_pulse();
    store_pulse();
    bar_pulse();
    store_pulse();
    sample_done("R7 waiting", 0);
    enq(MSG_COMMIT, 50, a);
    enq(MSG_COMMIT, 51, a);
    enq(MSG_COMMIT, 52, a);
    deq("R7 commit", MSG_COMMIT, 50);
    sample_done("R7 one left", 0);
    deq("R7 commit", MSG_COMMIT, 51);
    sample_done("R7 done", 1);
    deq("R7 later commit", MSG_COMMIT, 52);
    sample_done("R7 no extra pulse", 0);
  endtask

  task automatic t_overflow();
    logic a;
    for (int i = 0; i < 15; i++) store_pulse();
    @(negedge clk); #2 chk("R9 no ovf at max", int'(overflow), 0);
    store_pulse();
    @(negedge clk); #2 chk("R9 ovf set", int'(overflow), 1);
    bar_pulse();
    sample_done("R9 saturated wait", 0);
    for (int b = 0; b < 2; b++) begin
      int n = (b == 0) ? 8 : 7;
      for (int i = 0; i < n; i++) enq(MSG_COMMIT, 60 + i, a);
      for (int i = 0; i < n; i++) begin
        deq("R9 drain", MSG_COMMIT, 60 + i);
        if (!(b == 1 && i == n - 1)) sample_done("R9 not yet", 0);
      end
    end
    sample_done("R9 done after 15", 1);
    @(negedge clk); #2 chk("R9 ovf sticky", int'(overflow), 1);
  endtask

  initial begin
    #25 rst_ni = 1'b1;
    t_reset();
    t_fifo();
    t_bypass();
    t_commit();
    t_full();
    t_barrier_zero();
    t_barrier_wait();
    t_overflow();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(20 * 20000);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule